// File: doc/BRIEF.md
# Data-Space Address Generator

This block forms data-memory addresses for an 8-bit microcontroller core with separate program and data memories. The core's data space is unified. The 32 general-purpose byte registers, a 64-entry I/O window and 512 bytes of SRAM share one 16-bit address range. The block holds the register file itself. The six highest registers pair up into three 16-bit pointers. Each cycle the block takes an addressing-mode code, a pointer select, a small unsigned offset and a full direct address. It returns the effective address together with the region that address falls in. For register-region addresses it also returns the byte the register file holds there.

The pointer-based modes can move the selected pointer by one in either direction. Both bytes of the pointer are written back at the same clock edge. A separate mode sends the Z pointer toward program memory: it returns a word address and a byte-half select. Mode/pointer combinations that are not allowed are flagged and have no side effect. A plain write port and a plain read port on the register file serve the surrounding core.

Top module: `dspace_agen`

## Requirements
- R1: After an active-low reset, every register reads back as 0x00, so all three pointers are 0x0000.
- R2: A register write (`regWrEn`) takes effect at the next rising edge. `regRdData` always shows the register selected by `regRdIdx`.
- R3: The region code is decoded from `effAddr` as follows: 0x0000–0x001F gives 0 (register), 0x0020–0x005F gives 1 (I/O), 0x0060–0x025F gives 2 (SRAM), and any other address gives 3 (none). When the code is 0, `spaceRegData` equals the register numbered `effAddr[4:0]`; otherwise it is 0x00.
- R4: Mode 0 (direct) outputs `directAddr`. Mode 1 (I/O number) outputs `dispIo + 0x20`. In both modes `ptrSel` is ignored.
- R5: Mode 2 (indirect) outputs the selected pointer unchanged. `ptrSel` picks the pointer: 0 selects X = {r27,r26}, 1 selects Y = {r29,r28}, 2 selects Z = {r31,r30}. The low byte sits in the even register.
- R6: Mode 3 (post-increment) outputs the pointer. When `opValid` is high, the pointer then becomes pointer+1, wrapping modulo 2^16.
- R7: Mode 4 (pre-decrement) outputs pointer−1. When `opValid` is high, the pointer becomes pointer−1, wrapping modulo 2^16.
- R8: Mode 5 (displacement) outputs the pointer plus the zero-extended 6-bit `dispIo`. Only Y and Z are allowed, and the pointer never changes.
- R9: Mode 6 (program read) uses Z only. `effAddr` equals Z, `progWordAddr` equals Z[12:1], `progHighByte` equals Z[0], and the region code is 3.
- R10: The following cases raise `illegalOp`: mode 7, `ptrSel`=3 in modes 2–5, X in mode 5, and any pointer other than Z in mode 6. In these cases `effAddr` is 0, the region code is 3, and no pointer is written back.
- R11: A pointer write-back takes precedence over a register write aimed at either byte of the same pointer in the same cycle. A register write aimed at any other register still lands.
- R12: While `opValid` is low, the outputs are still computed, but no pointer is written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Qualifies pointer write-back for the current operation |
| opMode | input | 3 | Addressing-mode code (0..7) |
| ptrSel | input | 2 | Pointer select: 0=X, 1=Y, 2=Z, 3=reserved |
| dispIo | input | 6 | Displacement or I/O number |
| directAddr | input | 16 | Data-space address for direct mode |
| regWrEn | input | 1 | Register write strobe |
| regWrIdx | input | 5 | Register number to write |
| regWrData | input | 8 | Register write data |
| regRdIdx | input | 5 | Register number to read |
| regRdData | output | 8 | Register read data |
| effAddr | output | 16 | Effective data-space address |
| region | output | 2 | Region code: 0 reg, 1 I/O, 2 SRAM, 3 none |
| illegalOp | output | 1 | Disallowed mode/pointer combination |
| spaceRegData | output | 8 | Register byte at effAddr when region is 0 |
| progWordAddr | output | 12 | Program-memory word address from Z |
| progHighByte | output | 1 | High-byte select from Z bit 0 |

## Verification
The hardest case to reach from the ports is a pointer write-back that collides with a register write aimed at the same pointer byte in the same cycle. A second hard case is a pointer that steps across the 0xFFFF/0x0000 boundary. Uniform random stimulus almost never lines up either. Directed sequences therefore first load a pointer through the write port with 0xFFFF or 0x0000 and then step it. Another directed sequence fires a post-increment while the write port aims at that pointer's low byte. The random part biases register writes toward r26–r31 and direct addresses toward the region boundaries. This keeps pointers moving and produces collisions and boundary decodes far more often than uniform draws would.

// File: rtl/dspace_agen_pkg.sv
package dspace_agen_pkg;

  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_IONUM   = 3'd1,
    MODE_IND     = 3'd2,
    MODE_POSTINC = 3'd3,
    MODE_PREDEC  = 3'd4,
    MODE_DISP    = 3'd5,
    MODE_PROG    = 3'd6,
    MODE_RSVD    = 3'd7
  } agenMode_e;

  typedef enum logic [1:0] {
    RGN_REG  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selDirect;
    logic selIo;
    logic usePtr;
    logic addDisp;
    logic preDec;
    logic wbEn;
    logic wbInc;
    logic isProg;
    logic illegal;
  } agenCtl_t;

endpackage

// File: rtl/dspace_region_decode.sv
module dspace_region_decode
  import dspace_agen_pkg::*;
#(
  parameter int REG_COUNT  = 32,
  parameter int IO_COUNT   = 64,
  parameter int SRAM_BYTES = 512
) (
  input  logic [PTR_W-1:0] addr,
  output region_e          regionOut
);

  localparam int IO_BASE   = REG_COUNT;
  localparam int SRAM_BASE = IO_BASE + IO_COUNT;
  localparam int SRAM_END  = SRAM_BASE + SRAM_BYTES;

  always_comb begin
    if (addr < PTR_W'(IO_BASE))        regionOut = RGN_REG;
    else if (addr < PTR_W'(SRAM_BASE)) regionOut = RGN_IO;
    else if (addr < PTR_W'(SRAM_END))  regionOut = RGN_SRAM;
    else                               regionOut = RGN_NONE;
  end

endmodule

// File: rtl/dspace_agen_ctrl.sv
module dspace_agen_ctrl
  import dspace_agen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opMode,
  input  logic [1:0] ptrSel,
  output agenCtl_t   ctl
);

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Z = 2'd2;
  localparam logic [1:0] SEL_R = 2'd3;

  agenCtl_t raw;
  logic     bad;

  always_comb begin
    raw = '0;
    bad = 1'b0;
    case (agenMode_e'(opMode))
      MODE_DIRECT: raw.selDirect = 1'b1;
      MODE_IONUM:  raw.selIo     = 1'b1;
      MODE_IND: begin
        raw.usePtr = 1'b1;
        bad        = (ptrSel == SEL_R);
      end
      MODE_POSTINC: begin
        raw.usePtr = 1'b1;
        raw.wbInc  = 1'b1;
        raw.wbEn   = opValid;
        bad        = (ptrSel == SEL_R);
      end
      MODE_PREDEC: begin
        raw.usePtr = 1'b1;
        raw.preDec = 1'b1;
        raw.wbEn   = opValid;
        bad        = (ptrSel == SEL_R);
      end
      MODE_DISP: begin
        raw.usePtr  = 1'b1;
        raw.addDisp = 1'b1;
        bad         = (ptrSel == SEL_R) || (ptrSel == SEL_X);
      end
      MODE_PROG: begin
        raw.isProg = 1'b1;
        bad        = (ptrSel != SEL_Z);
      end
      default: bad = 1'b1;
    endcase
  end

  always_comb begin
    if (bad) begin
      ctl         = '0;
      ctl.illegal = 1'b1;
    end else begin
      ctl = raw;
    end
  end

  // R12: write-back only with a qualified operation
  p_wb_needs_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !ctl.wbEn);

  // R10: illegal combinations never produce a write-back strobe
  p_illegal_no_wb_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.illegal |-> !ctl.wbEn);

  // R5: pointer-based modes only with a real pointer
  p_ptr_sel_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.usePtr |-> (ptrSel != SEL_R));

  // R4: at most one address source per cycle
  p_one_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selDirect, ctl.selIo, ctl.usePtr, ctl.isProg}));

endmodule

// File: rtl/dspace_agen_dp.sv
module dspace_agen_dp
  import dspace_agen_pkg::*;
#(
  parameter int REG_COUNT   = 32,
  parameter int IO_COUNT    = 64,
  parameter int SRAM_BYTES  = 512,
  parameter int DISP_W      = 6,
  parameter int PROG_WORD_W = 12,
  localparam int IDX_W      = $clog2(REG_COUNT)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  agenCtl_t               ctl,
  input  logic [1:0]             ptrSel,
  input  logic [DISP_W-1:0]      dispIo,
  input  logic [PTR_W-1:0]       directAddr,
  input  logic                   regWrEn,
  input  logic [IDX_W-1:0]       regWrIdx,
  input  logic [7:0]             regWrData,
  input  logic [IDX_W-1:0]       regRdIdx,
  output logic [7:0]             regRdData,
  output logic [PTR_W-1:0]       effAddr,
  output logic [1:0]             region,
  output logic                   illegalOp,
  output logic [7:0]             spaceRegData,
  output logic [PROG_WORD_W-1:0] progWordAddr,
  output logic                   progHighByte
);

  localparam int NUM_PTR  = 3;
  localparam int PTR_BASE = REG_COUNT - 2 * NUM_PTR;
  localparam int IO_BASE  = REG_COUNT;

  logic [7:0]                   rf [REG_COUNT];
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrVal;
  logic [PTR_W-1:0]             ptrCur;
  logic [PTR_W-1:0]             nextPtr;
  logic [PTR_W-1:0]             dispExt;
  logic [IDX_W-1:0]             loIdx;
  logic [IDX_W-1:0]             hiIdx;
  logic [PTR_W-1:0]             rawAddr;
  region_e                      decRegion;

  // pointer pairs, low byte in the even register
  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    assign ptrVal[p] = {rf[PTR_BASE + 2 * p + 1], rf[PTR_BASE + 2 * p]};
  end

  always_comb begin
    case (ptrSel)
      2'd0:    ptrCur = ptrVal[0];
      2'd1:    ptrCur = ptrVal[1];
      2'd2:    ptrCur = ptrVal[2];
      default: ptrCur = '0;
    endcase
  end

  assign loIdx   = IDX_W'(PTR_BASE) + IDX_W'({ptrSel, 1'b0});
  assign hiIdx   = loIdx + IDX_W'(1);
  assign dispExt = {{(PTR_W - DISP_W){1'b0}}, dispIo};
  assign nextPtr = ctl.wbInc ? ptrCur + PTR_W'(1) : ptrCur - PTR_W'(1);

  // register file: pointer write-back outranks the plain write port
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_rf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   rf[g] <= '0;
      else if (ctl.wbEn && loIdx == IDX_W'(g))     rf[g] <= nextPtr[7:0];
      else if (ctl.wbEn && hiIdx == IDX_W'(g))     rf[g] <= nextPtr[15:8];
      else if (regWrEn && regWrIdx == IDX_W'(g))   rf[g] <= regWrData;
    end
  end

  always_comb begin
    if (ctl.selDirect)   rawAddr = directAddr;
    else if (ctl.selIo)  rawAddr = PTR_W'(IO_BASE) + dispExt;
    else if (ctl.usePtr) begin
      if (ctl.preDec)       rawAddr = ptrCur - PTR_W'(1);
      else if (ctl.addDisp) rawAddr = ptrCur + dispExt;
      else                  rawAddr = ptrCur;
    end
    else if (ctl.isProg) rawAddr = ptrVal[2];
    else                 rawAddr = '0;
  end

  dspace_region_decode #(
    .REG_COUNT (REG_COUNT),
    .IO_COUNT  (IO_COUNT),
    .SRAM_BYTES(SRAM_BYTES)
  ) u_rdec (
    .addr     (rawAddr),
    .regionOut(decRegion)
  );

  assign effAddr      = rawAddr;
  assign illegalOp    = ctl.illegal;
  assign region       = (ctl.illegal || ctl.isProg) ? RGN_NONE : decRegion;
  assign spaceRegData = (region == RGN_REG) ? rf[rawAddr[IDX_W-1:0]] : 8'h00;
  assign regRdData    = rf[regRdIdx];
  assign progWordAddr = ptrVal[2][PROG_WORD_W:1];
  assign progHighByte = ptrVal[2][0];

  // R6: post-increment advances the chosen pointer by one
  p_postinc_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wbEn && ctl.wbInc) |=> (ptrVal[$past(ptrSel)] == $past(ptrCur) + PTR_W'(1)));

  // R7: pre-decrement presents and stores pointer minus one
  p_predec_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wbEn && ctl.preDec) |=> (ptrVal[$past(ptrSel)] == $past(effAddr)));

  // R8: displacement access leaves all pointers untouched
  p_disp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addDisp && !regWrEn) |=> $stable(ptrVal));

  // R10: illegal operation leaves all pointers untouched
  p_illegal_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.illegal && !regWrEn) |=> $stable(ptrVal));

  // R4: I/O-number mode always lands in the I/O region
  p_io_region_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selIo |-> (region == RGN_IO));

  // R9: program read reports no data region and points at Z
  p_prog_none_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.isProg |-> (region == RGN_NONE && effAddr == ptrVal[2]));

endmodule

// File: rtl/dspace_agen.sv
module dspace_agen
  import dspace_agen_pkg::*;
#(
  parameter int REG_COUNT   = 32,
  parameter int IO_COUNT    = 64,
  parameter int SRAM_BYTES  = 512,
  parameter int DISP_W      = 6,
  parameter int PROG_WORD_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          opValid,
  input  logic [2:0]                    opMode,
  input  logic [1:0]                    ptrSel,
  input  logic [DISP_W-1:0]             dispIo,
  input  logic [15:0]                   directAddr,
  input  logic                          regWrEn,
  input  logic [$clog2(REG_COUNT)-1:0]  regWrIdx,
  input  logic [7:0]                    regWrData,
  input  logic [$clog2(REG_COUNT)-1:0]  regRdIdx,
  output logic [7:0]                    regRdData,
  output logic [15:0]                   effAddr,
  output logic [1:0]                    region,
  output logic                          illegalOp,
  output logic [7:0]                    spaceRegData,
  output logic [PROG_WORD_W-1:0]        progWordAddr,
  output logic                          progHighByte
);

  agenCtl_t ctl;

  dspace_agen_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opMode (opMode),
    .ptrSel (ptrSel),
    .ctl    (ctl)
  );

  dspace_agen_dp #(
    .REG_COUNT  (REG_COUNT),
    .IO_COUNT   (IO_COUNT),
    .SRAM_BYTES (SRAM_BYTES),
    .DISP_W     (DISP_W),
    .PROG_WORD_W(PROG_WORD_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .ptrSel      (ptrSel),
    .dispIo      (dispIo),
    .directAddr  (directAddr),
    .regWrEn     (regWrEn),
    .regWrIdx    (regWrIdx),
    .regWrData   (regWrData),
    .regRdIdx    (regRdIdx),
    .regRdData   (regRdData),
    .effAddr     (effAddr),
    .region      (region),
    .illegalOp   (illegalOp),
    .spaceRegData(spaceRegData),
    .progWordAddr(progWordAddr),
    .progHighByte(progHighByte)
  );

endmodule

// File: tb/sim_dspace_agen.sv
module sim_dspace_agen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opMode;
  logic [1:0]  ptrSel;
  logic [5:0]  dispIo;
  logic [15:0] directAddr;
  logic        regWrEn;
  logic [4:0]  regWrIdx;
  logic [7:0]  regWrData;
  logic [4:0]  regRdIdx;
  logic [7:0]  regRdData;
  logic [15:0] effAddr;
  logic [1:0]  region;
  logic        illegalOp;
  logic [7:0]  spaceRegData;
  logic [11:0] progWordAddr;
  logic        progHighByte;

  int   nTests = 0;
  int   nFails = 0;
  bit   finished = 1'b0;
  logic [7:0] m [32];

  always #2 clk = ~clk;

  dspace_agen u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opMode(opMode), .ptrSel(ptrSel),
    .dispIo(dispIo), .directAddr(directAddr), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .regRdIdx(regRdIdx), .regRdData(regRdData),
    .effAddr(effAddr), .region(region), .illegalOp(illegalOp),
    .spaceRegData(spaceRegData), .progWordAddr(progWordAddr), .progHighByte(progHighByte)
  );

  function automatic logic [1:0] rgnOf(input logic [15:0] a);
    if (a < 16'h0020)      return 2'd0;
    else if (a < 16'h0060) return 2'd1;
    else if (a < 16'h0260) return 2'd2;
    else                   return 2'd3;
  endfunction

  function automatic logic isIllegal(input logic [2:0] md, input logic [1:0] sel);
    if (md == 3'd7) return 1'b1;
    if (md >= 3'd2 && md <= 3'd5 && sel == 2'd3) return 1'b1;
    if (md == 3'd5 && sel == 2'd0) return 1'b1;
    if (md == 3'd6 && sel != 2'd2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic runOp(input logic v, input logic [2:0] md, input logic [1:0] sel,
                       input logic [5:0] dp, input logic [15:0] da, input logic we,
                       input logic [4:0] wi, input logic [7:0] wd, input logic [4:0] ri);
    logic [15:0] p, z, eEa, np;
    logic        eIll;
    logic [1:0]  eRg;
    int          base;
    string       rq;
    @(negedge clk);
    opValid = v; opMode = md; ptrSel = sel; dispIo = dp; directAddr = da;
    regWrEn = we; regWrIdx = wi; regWrData = wd; regRdIdx = ri;
    #1;
    base = 26 + 2 * int'(sel);
    p    = (sel == 2'd3) ? 16'h0000 : {m[base + 1], m[base]};
    z    = {m[31], m[30]};
    eIll = isIllegal(md, sel);
    case (md)
      3'd0: begin eEa = da;                   rq = "R4"; end
      3'd1: begin eEa = 16'h0020 + 16'(dp);   rq = "R4"; end
      3'd2: begin eEa = p;                    rq = "R5"; end
      3'd3: begin eEa = p;                    rq = "R6"; end
      3'd4: begin eEa = p - 16'd1;            rq = "R7"; end
      3'd5: begin eEa = p + 16'(dp);          rq = "R8"; end
      3'd6: begin eEa = z;                    rq = "R9"; end
      default: begin eEa = 16'h0000;          rq = "R10"; end
    endcase
    if (eIll) begin eEa = 16'h0000; rq = "R10"; end
    eRg = (eIll || md == 3'd6) ? 2'd3 : rgnOf(eEa);
    chk(rq, 32'(effAddr), 32'(eEa));
    chk("R10", 32'(illegalOp), 32'(eIll));
    chk("R3", 32'(region), 32'(eRg));
    chk("R3", 32'(spaceRegData), (eRg == 2'd0) ? 32'(m[eEa[4:0]]) : 32'h0);
    chk("R2", 32'(regRdData), 32'(m[ri]));
    if (md == 3'd6 && !eIll) begin
      chk("R9", 32'(progWordAddr), 32'(z[12:1]));
      chk("R9", 32'(progHighByte), 32'(z[0]));
    end
    @(posedge clk);
    if (we) m[wi] = wd;
    if (v && !eIll && (md == 3'd3 || md == 3'd4)) begin
      np = (md == 3'd3) ? p + 16'd1 : p - 16'd1;
      m[base]     = np[7:0];
      m[base + 1] = np[15:8];
    end
  endtask

  task automatic wrReg(input logic [4:0] idx, input logic [7:0] val);
    runOp(1'b0, 3'd0, 2'd0, 6'd0, 16'h0000, 1'b1, idx, val, 5'd0);
  endtask

  task automatic rdReg(input logic [4:0] idx, output logic [7:0] val);
    @(negedge clk);
    opValid = 1'b0; regWrEn = 1'b0; regRdIdx = idx;
    #1;
    val = regRdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    logic [2:0] md;
    logic [4:0] wi;
    logic [15:0] da;
    void'($urandom(32'd20240611));
    opValid = 0; opMode = 0; ptrSel = 0; dispIo = 0; directAddr = 0;
    regWrEn = 0; regWrIdx = 0; regWrData = 0; regRdIdx = 0;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    // R1: reset state of every register
    for (int i = 0; i < 32; i++) begin
      rdReg(5'(i), lo);
      chk("R1", 32'(lo), 32'h0);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R3: boundary decodes through direct mode
    runOp(1, 0, 0, 0, 16'h001F, 0, 0, 0, 0);
    runOp(1, 0, 0, 0, 16'h0020, 0, 0, 0, 0);
    runOp(1, 0, 0, 0, 16'h005F, 0, 0, 0, 0);
    runOp(1, 0, 0, 0, 16'h0060, 0, 0, 0, 0);
    runOp(1, 0, 0, 0, 16'h025F, 0, 0, 0, 0);
    runOp(1, 0, 0, 0, 16'h0260, 0, 0, 0, 0);
    runOp(1, 1, 3, 63, 16'h0000, 0, 0, 0, 0);

    // R6: X wraps from 0xFFFF to 0x0000
    wrReg(26, 8'hFF); wrReg(27, 8'hFF);
    runOp(1, 3, 0, 0, 0, 0, 0, 0, 26);
    rdReg(26, lo); rdReg(27, hi);
    chk("R6", 32'({hi, lo}), 32'h0000);

    // R7: Y wraps from 0x0000 to 0xFFFF
    wrReg(28, 8'h00); wrReg(29, 8'h00);
    runOp(1, 4, 1, 0, 0, 0, 0, 0, 28);
    rdReg(28, lo); rdReg(29, hi);
    chk("R7", 32'({hi, lo}), 32'hFFFF);

    // R11: write-back beats a same-cycle write to the pointer byte
    wrReg(26, 8'h34); wrReg(27, 8'h12);
    runOp(1, 3, 0, 0, 0, 1, 26, 8'hAA, 0);
    rdReg(26, lo); rdReg(27, hi);
    chk("R11", 32'({hi, lo}), 32'h1235);
    // R11: write to an unrelated register still lands during write-back
    runOp(1, 3, 1, 0, 0, 1, 5, 8'h5A, 0);
    rdReg(5, lo);
    chk("R11", 32'(lo), 32'h5A);

    // R12: unqualified post-increment leaves Z alone
    wrReg(30, 8'h41); wrReg(31, 8'h02);
    runOp(0, 3, 2, 0, 0, 0, 0, 0, 0);
    rdReg(30, lo); rdReg(31, hi);
    chk("R12", 32'({hi, lo}), 32'h0241);

    // R8 and R9: displacement past SRAM end, program read from Z
    wrReg(30, 8'h50);
    runOp(1, 5, 2, 63, 0, 0, 0, 0, 30);
    runOp(1, 6, 2, 0, 0, 0, 0, 0, 31);
    runOp(1, 6, 1, 0, 0, 0, 0, 0, 31);
    runOp(1, 5, 0, 5, 0, 0, 0, 0, 26);
    runOp(1, 7, 2, 0, 0, 0, 0, 0, 26);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      md = 3'($urandom_range(0, 7));
      wi = ($urandom_range(0, 3) != 0) ? 5'($urandom_range(26, 31)) : 5'($urandom_range(0, 31));
      da = ($urandom_range(0, 3) != 0) ? 16'($urandom_range(0, 16'h0280)) : 16'($urandom);
      runOp(($urandom_range(0, 7) != 0), md, 2'($urandom_range(0, 3)), 6'($urandom),
            da, ($urandom_range(0, 3) == 0), wi, 8'($urandom),
            ($urandom_range(0, 1) != 0) ? 5'($urandom_range(26, 31)) : 5'($urandom));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule